// File: doc/BRIEF.md
# Modem Transmit Test-Pattern and Scrambler Bit Path

This block is the serial bit path on the transmit side of a DPSK modem. It runs on the transmit bit clock, which is shown as a one-cycle enable `bit_en`. On each enabled cycle it takes one data bit from `txd_in`. It either passes that bit on or replaces it with a test pattern: an alternating mark/space sequence, a constant mark or a constant space. The chosen bit then goes through a self-synchronizing scrambler, or goes around the scrambler when bypass is set. One output bit appears on `tx_out` for each enabled cycle.

A small write port loads the pattern-select and bypass fields together. The test patterns enter ahead of the scrambler, so they are scrambled unless bypass is set. While bypass is set, the scrambler history is frozen, so scrambling resumes from the same state when bypass is cleared. The scrambler polynomial is 1 + x^-14 + x^-17, and both tap positions are parameters.

Top module: `txp_path`

## Requirements
- R1: With pattern select 2'b00 and bypass set, the output bit for an enabled cycle equals the `txd_in` value sampled in that cycle.
- R2: Pattern select 2'b01 replaces data with alternating bits. The first enabled cycle after a write produces mark (1), and each later enabled cycle inverts the bit.
- R3: Pattern select 2'b10 produces a constant mark (1) ahead of the scrambler. With bypass set, `tx_out` is 1.
- R4: Pattern select 2'b11 produces a constant space (0) ahead of the scrambler. With bypass set, `tx_out` is 0.
- R5: With bypass clear, each output bit is s(n) = d(n) XOR s(n-14) XOR s(n-17), where s is the sequence of past output bits held in a 17-bit history register.
- R6: With bypass set, the output is the selected bit unscrambled and the scrambler history does not change. After bypass is cleared, scrambling continues from the history held before the bypass.
- R7: `tx_out` changes only on the clock edge of a cycle with `bit_en` high. At all other times it holds its value.
- R8: A write with `cfg_wr` high loads `cfg_pat` and `cfg_byp`. The new values apply from the next enabled cycle. An enabled cycle that coincides with the write still uses the old settings.
- R9: Synchronous reset clears `tx_out` and the scrambler history to 0. It selects pattern 2'b00 with bypass clear and sets the alternating phase to mark.
- R10: Test patterns are scrambled when bypass is clear. After reset, 14 constant-mark bits give 1s, and the 15th gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | One-cycle transmit bit-clock enable |
| txd_in | input | 1 | Serial transmit data bit |
| cfg_wr | input | 1 | Write strobe for the pattern and bypass fields |
| cfg_pat | input | 2 | Pattern select: 00 data, 01 alternating, 10 mark, 11 space |
| cfg_byp | input | 1 | Scrambler bypass: 1 routes bits around the scrambler |
| tx_out | output | 1 | Transmitted bit, updated once per enabled cycle |

## Verification
Every result is registered once. An enabled cycle's bit appears on `tx_out` right after that cycle's rising edge. The bench drives inputs at the falling edge, lets one rising edge pass, and compares at the next falling edge, so each check reads the bit of the cycle just driven. A settings write takes effect one bit later than the edge that loads it. The reference model in the bench therefore computes the output with the settings in force before each edge, and applies the write afterwards. This matches the same-cycle case in R8.

// File: rtl/txp_pkg.sv
package txp_pkg;
   typedef enum logic [1:0] {
      PAT_DATA  = 2'b00,
      PAT_ALT   = 2'b01,
      PAT_MARK  = 2'b10,
      PAT_SPACE = 2'b11
   } pat_e;

   typedef struct packed {
      pat_e pat;
      logic byp;
   } txp_cfg_t;
endpackage

// File: rtl/txp_cfg.sv
module txp_cfg
   import txp_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       cfg_wr,
   input  logic [1:0] cfg_pat,
   input  logic       cfg_byp,
   output txp_cfg_t   cfg
);
   always_ff @(posedge clk) begin
      if (rst) begin
         cfg.pat <= PAT_DATA;
         cfg.byp <= 1'b0;
      end else if (cfg_wr) begin
         cfg.pat <= pat_e'(cfg_pat);
         cfg.byp <= cfg_byp;
      end
   end

   AST_CFG_LOAD: assert property (@(posedge clk) disable iff (rst)
      cfg_wr |=> (cfg.pat == pat_e'($past(cfg_pat)) && cfg.byp == $past(cfg_byp))); // R8
   AST_CFG_RESET: assert property (@(posedge clk)
      rst |=> (cfg.pat == PAT_DATA && !cfg.byp)); // R9
endmodule

// File: rtl/txp_patsel.sv
module txp_patsel
   import txp_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic bit_en,
   input  logic restart,
   input  pat_e pat,
   input  logic txd_in,
   output logic sel_bit
);
   logic alt_phase;

   always_comb begin
      unique case (pat)
         PAT_DATA:  sel_bit = txd_in;
         PAT_ALT:   sel_bit = alt_phase;
         PAT_MARK:  sel_bit = 1'b1;
         PAT_SPACE: sel_bit = 1'b0;
         default:   sel_bit = txd_in;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst || restart)
         alt_phase <= 1'b1;
      else if (bit_en && pat == PAT_ALT)
         alt_phase <= ~alt_phase;
   end

   AST_ALT_TOGGLE: assert property (@(posedge clk) disable iff (rst)
      (bit_en && !restart && pat == PAT_ALT) |=> (alt_phase != $past(alt_phase))); // R2
   AST_ALT_RESTART: assert property (@(posedge clk)
      (rst || restart) |=> alt_phase); // R2
endmodule

// File: rtl/txp_scrambler.sv
module txp_scrambler #(
   parameter int SCR_LEN = 17,
   parameter int SCR_TAP = 14
) (
   input  logic clk,
   input  logic rst,
   input  logic bit_en,
   input  logic byp,
   input  logic din,
   output logic dout
);
   localparam int LAST = SCR_LEN - 1;
   localparam int TAPI = SCR_TAP - 1;

   generate
      if (SCR_TAP < 1 || SCR_TAP >= SCR_LEN) begin : g_bad_taps
         $error("txp_scrambler: SCR_TAP must lie in 1..SCR_LEN-1");
      end
   endgenerate

   logic [LAST:0] hist;
   logic [LAST:0] hist_nxt;
   logic          fb;
   logic          adv;

   assign fb   = din ^ hist[TAPI] ^ hist[LAST];
   assign adv  = bit_en && !byp;
   assign dout = byp ? din : fb;

   assign hist_nxt[0] = fb;
   generate
      for (genvar g = 1; g < SCR_LEN; g++) begin : g_stage
         assign hist_nxt[g] = hist[g-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         hist <= '0;
      else if (adv)
         hist <= hist_nxt;
   end

   AST_SCR_FROZEN: assert property (@(posedge clk) disable iff (rst)
      (bit_en && byp) |=> $stable(hist)); // R6
   AST_SCR_SHIFT: assert property (@(posedge clk) disable iff (rst)
      (bit_en && !byp) |=> (hist[LAST:1] == $past(hist[LAST-1:0]))); // R5
   AST_SCR_CLEAR: assert property (@(posedge clk)
      rst |=> (hist == '0)); // R9
endmodule

// File: rtl/txp_path.sv
module txp_path
   import txp_pkg::*;
#(
   parameter int SCR_LEN = 17,
   parameter int SCR_TAP = 14
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       bit_en,
   input  logic       txd_in,
   input  logic       cfg_wr,
   input  logic [1:0] cfg_pat,
   input  logic       cfg_byp,
   output logic       tx_out
);
   txp_cfg_t cfg;
   logic     sel_bit;
   logic     scr_bit;

   txp_cfg u_cfg (
      .clk     (clk),
      .rst     (rst),
      .cfg_wr  (cfg_wr),
      .cfg_pat (cfg_pat),
      .cfg_byp (cfg_byp),
      .cfg     (cfg)
   );

   txp_patsel u_pat (
      .clk     (clk),
      .rst     (rst),
      .bit_en  (bit_en),
      .restart (cfg_wr),
      .pat     (cfg.pat),
      .txd_in  (txd_in),
      .sel_bit (sel_bit)
   );

   txp_scrambler #(.SCR_LEN(SCR_LEN), .SCR_TAP(SCR_TAP)) u_scr (
      .clk    (clk),
      .rst    (rst),
      .bit_en (bit_en),
      .byp    (cfg.byp),
      .din    (sel_bit),
      .dout   (scr_bit)
   );

   always_ff @(posedge clk) begin
      if (rst)
         tx_out <= 1'b0;
      else if (bit_en)
         tx_out <= scr_bit;
   end

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
      !bit_en |=> $stable(tx_out)); // R7
   AST_MARK_BYP: assert property (@(posedge clk) disable iff (rst)
      (bit_en && cfg.byp && cfg.pat == PAT_MARK) |=> tx_out); // R3
   AST_SPACE_BYP: assert property (@(posedge clk) disable iff (rst)
      (bit_en && cfg.byp && cfg.pat == PAT_SPACE) |=> !tx_out); // R4
   AST_DATA_BYP: assert property (@(posedge clk) disable iff (rst)
      (bit_en && cfg.byp && cfg.pat == PAT_DATA) |=> (tx_out == $past(txd_in))); // R1
   AST_OUT_RESET: assert property (@(posedge clk)
      rst |=> !tx_out); // R9
endmodule

// File: tb/txp_path_tb_top.sv
module txp_path_tb_top;
   localparam int CLK_T  = 10;
   localparam int LEN    = 17;
   localparam int TAP    = 14;
   localparam int NVEC   = 36;
   localparam int WD_CYC = 200000;

   logic clk = 1'b0;
   logic rst, bit_en, txd_in, cfg_wr, cfg_byp;
   logic [1:0] cfg_pat;
   logic tx_out;

   int checks = 0;
   int fails  = 0;

   // reference model state
   logic [1:0]     m_pat;
   logic           m_byp, m_alt, m_out;
   logic [LEN-1:0] m_hist;

   always #(CLK_T/2) clk = ~clk;

   txp_path dut_i (
      .clk(clk), .rst(rst), .bit_en(bit_en), .txd_in(txd_in),
      .cfg_wr(cfg_wr), .cfg_pat(cfg_pat), .cfg_byp(cfg_byp), .tx_out(tx_out)
   );

   // vector fields: {wr, pat[1:0], byp, en, txd, req[3:0]}
   localparam logic [9:0] VEC [0:NVEC-1] = '{
      10'b1_00_1_0_0_1000, 10'b0_00_0_1_1_0001, 10'b0_00_0_1_0_0001,
      10'b0_00_0_1_1_0001, 10'b0_00_0_1_1_0001, 10'b0_00_0_1_0_0001,
      10'b1_00_0_0_0_1000, 10'b0_00_0_1_1_0101, 10'b0_00_0_1_0_0101,
      10'b0_00_0_1_1_0101, 10'b0_00_0_1_0_0101, 10'b0_00_0_1_1_0101,
      10'b1_01_1_0_0_1000, 10'b0_00_0_1_0_0010, 10'b0_00_0_1_1_0010,
      10'b0_00_0_1_0_0010, 10'b0_00_0_1_1_0010, 10'b0_00_0_1_0_0010,
      10'b1_10_1_0_0_1000, 10'b0_00_0_1_0_0011, 10'b0_00_0_1_0_0011,
      10'b1_11_1_0_0_1000, 10'b0_00_0_1_1_0100, 10'b0_00_0_1_1_0100,
      10'b1_00_1_0_0_1000, 10'b0_00_0_1_1_0110, 10'b0_00_0_1_0_0110,
      10'b0_00_0_1_1_0110, 10'b1_00_0_0_0_1000, 10'b0_00_0_1_1_0110,
      10'b0_00_0_1_0_0110, 10'b0_00_0_1_1_0110, 10'b0_00_0_0_1_0111,
      10'b0_00_0_0_0_0111, 10'b1_01_0_1_1_1000, 10'b0_00_0_1_0_0010
   };

   function automatic string tag(input logic [3:0] r);
      case (r)
         4'd1: return "R1";  4'd2: return "R2";  4'd3: return "R3";
         4'd4: return "R4";  4'd5: return "R5";  4'd6: return "R6";
         4'd7: return "R7";  4'd8: return "R8";  4'd9: return "R9";
         default: return "R10";
      endcase
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: tx_out=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   // update model as the design does at one rising edge
   task automatic model_edge(input logic wr, input logic [1:0] pat, input logic byp,
                             input logic en, input logic txd);
      logic sel, fb;
      case (m_pat)
         2'b00: sel = txd;
         2'b01: sel = m_alt;
         2'b10: sel = 1'b1;
         default: sel = 1'b0;
      endcase
      fb = sel ^ m_hist[TAP-1] ^ m_hist[LEN-1];
      if (en) begin
         m_out = m_byp ? sel : fb;
         if (!m_byp) m_hist = {m_hist[LEN-2:0], fb};
      end
      if (wr) m_alt = 1'b1;
      else if (en && m_pat == 2'b01) m_alt = ~m_alt;
      if (wr) begin m_pat = pat; m_byp = byp; end
   endtask

   task automatic step(input logic wr, input logic [1:0] pat, input logic byp,
                       input logic en, input logic txd, input string req);
      @(negedge clk);
      cfg_wr = wr; cfg_pat = pat; cfg_byp = byp; bit_en = en; txd_in = txd;
      @(posedge clk);
      model_edge(wr, pat, byp, en, txd);
      @(negedge clk);
      cfg_wr = 1'b0; bit_en = 1'b0;
      check(req, tx_out, m_out);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; bit_en = 1'b0; cfg_wr = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      m_pat = 2'b00; m_byp = 1'b0; m_alt = 1'b1; m_out = 1'b0; m_hist = '0;
   endtask

   initial begin
      #(CLK_T * WD_CYC);
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      rst = 1'b1; bit_en = 1'b0; txd_in = 1'b0; cfg_wr = 1'b0;
      cfg_pat = 2'b00; cfg_byp = 1'b0;
      do_reset();
      check("R9", tx_out, 1'b0);
      // R9: reset selects data with scrambler on; zero history gives out = data
      step(1'b0, 2'b00, 1'b0, 1'b1, 1'b1, "R9");
      check("R9", tx_out, 1'b1);

      // R10: constant mark scrambled from cleared history
      do_reset();
      step(1'b1, 2'b10, 1'b0, 1'b0, 1'b0, "R8");
      for (int i = 0; i < 15; i++) begin
         step(1'b0, 2'b00, 1'b0, 1'b1, 1'b0, "R10");
         check("R10", tx_out, (i < 14) ? 1'b1 : 1'b0);
      end

      // table walk
      do_reset();
      for (int v = 0; v < NVEC; v++) begin
         step(VEC[v][9], VEC[v][8:7], VEC[v][6], VEC[v][5], VEC[v][4], tag(VEC[v][3:0]));
      end

      // R7: output holds while enable is low and data toggles
      begin
         logic held;
         held = tx_out;
         for (int i = 0; i < 4; i++) begin
            step(1'b0, 2'b00, 1'b0, 1'b0, i[0], "R7");
            check("R7", tx_out, held);
         end
      end

      // R6: bypass freezes history; resume matches the model
      step(1'b1, 2'b00, 1'b1, 1'b0, 1'b0, "R8");
      for (int i = 0; i < 6; i++) step(1'b0, 2'b00, 1'b0, 1'b1, i[1], "R6");
      step(1'b1, 2'b00, 1'b0, 1'b0, 1'b0, "R8");
      for (int i = 0; i < 20; i++) step(1'b0, 2'b00, 1'b0, 1'b1, i[0] ^ i[2], "R6");

      // R2: alternating pattern bypassed, explicit mark-first sequence
      step(1'b1, 2'b01, 1'b1, 1'b0, 1'b0, "R8");
      for (int i = 0; i < 4; i++) begin
         step(1'b0, 2'b00, 1'b0, 1'b1, 1'b0, "R2");
         check("R2", tx_out, ~i[0]);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule